// File: doc/BRIEF.md
# DRAM Bank Timing Enforcement Unit

This unit watches the commands a DRAM controller issues and tells the scheduler, bank by bank, which command classes are currently legal. It tracks sixteen banks, arranged as four rows of four banks. For each bank it publishes three ready flags: one for activate, one for read/write, and one for precharge. A 32-bit timing word sets the row-to-column delay, the minimum row-open time, the read/write-to-precharge spacing, the precharge-to-activate delay and an idle timeout. Software or boot logic writes this word.

Two timers ask the scheduler to close rows. Each bank has its own maximum-open-time counter. It raises a force-precharge request once that bank has been open for 120 µs. A single idle timer counts the clocks that pass without any command. When the programmed limit is reached while any row is open, it raises a precharge-all request. If a command reaches a bank that is not ready for it, the unit sets a sticky per-bank violation flag.

The unit only observes commands and flags timing. It does not schedule commands, generate refresh, map addresses or handle data.

Top module: `bank_timing_unit`

## Requirements
- R1: After reset the timing word is zero and all banks are closed. Every activate and precharge flag is 1. Every read/write, force-precharge and violation flag is 0, and the precharge-all request is 0. The all-zero word gives a row-to-column delay of 3, a minimum open time of 8, a precharge-to-activate delay of 3, a read/write-to-precharge spacing of 3 and a disabled idle timer.
- R2: After an activate to a bank, its read/write flag rises exactly N clocks later and stays low before that. N is set by bits 3:2 of the timing word: code 10 gives 2, and 01, 00 and 11 give 3 (reserved codes take the longest value). The read/write and activate flags of one bank are never both 1.
- R3: After an activate, the bank's precharge flag stays low until the minimum open time has passed. That time is set by bits 10:9: code 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5 clocks.
- R4: After a precharge to an open bank, its activate flag rises exactly N clocks later. N is set by bits 1:0: code 10 gives 2, and all other codes give 3.
- R5: After a read/write, the bank's precharge flag stays low for N clocks. N is set by bits 6:5: code 10 gives 2, and all other codes give 3.
- R6: The idle limit is set by bits 17:15. Code 000 means the timer never expires. Code 001 gives 0 clocks, 010 gives 8, 011 gives 16, and 100 through 111 give 64. When the count of command-free clocks reaches the limit and at least one bank is open, the precharge-all request is 1. With code 010, the request rises 9 clocks after the command edge.
- R7: Any command restarts the idle count. While any force-precharge request is pending, the idle count holds its value.
- R8: A bank that has been open for CLK_MHZ×120 clocks raises its force-precharge flag. The flag stays raised until that bank is precharged. Bit 11 may hold either value and the limit is the same.
- R9: An activate, read/write or precharge sent to a bank whose matching flag is 0 sets that bank's violation bit. The bit stays set until reset. A precharge to a closed bank does nothing: it raises no violation and does not change the bank's activate flag.
- R10: A precharge-all command closes every open bank and starts each bank's precharge-to-activate delay.
- R11: A command to one bank leaves the flags of every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Load the timing word |
| cfg_data_i | input | 32 | Timing word value |
| cmd_act_i | input | 1 | Activate issued to cmd_bank_i |
| cmd_rw_i | input | 1 | Read or write issued to cmd_bank_i |
| cmd_pre_i | input | 1 | Precharge issued to cmd_bank_i |
| cmd_prea_i | input | 1 | Precharge of all banks issued |
| cmd_bank_i | input | 4 | Bank index (row × 4 + bank) |
| act_ok_o | output | 16 | Activate legal, per bank |
| rw_ok_o | output | 16 | Read/write legal, per bank |
| pre_ok_o | output | 16 | Precharge legal, per bank |
| force_pre_o | output | 16 | Bank held open too long |
| pre_all_req_o | output | 1 | Idle timeout, precharge all open rows |
| violation_o | output | 16 | Sticky per-bank timing violation |

## Verification
The main function is tried with five timing words. Each word uses a different bank, and each mixes a short code, a long code and reserved codes across the four delay fields. Measuring the first legal clock of each flag therefore separates one field's decoding from another's, and shows that bits reserved by position or by value are ignored. The idle timer is tried with every class of limit, including never and zero. It is also tried with a command issued partway through a countdown, which separates a restart from a free-running count. A long open row with periodic reads, followed by a quiet stretch, separates the max-open counter from the idle timer and shows the idle count holding.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;
  localparam int DLY_W  = 4;
  localparam int IDLE_W = 7;

  localparam int IDLE_LSB = 15;
  localparam int TRAS_LSB = 9;
  localparam int CL_LSB   = 5;
  localparam int RCD_LSB  = 2;
  localparam int RP_LSB   = 0;

  typedef struct packed {
    logic [DLY_W-1:0] trcd;
    logic [DLY_W-1:0] tras;
    logic [DLY_W-1:0] trp;
    logic [DLY_W-1:0] tcl;
  } bank_dly_t;

  typedef struct packed {
    bank_dly_t         dly;
    logic              idle_en;
    logic [IDLE_W-1:0] idle_lim;
  } timing_t;

  // two-value fields: code 10 short, anything else (incl. reserved) long
  function automatic logic [DLY_W-1:0] dec_two_three(input logic [1:0] code);
    return (code == 2'b10) ? DLY_W'(2) : DLY_W'(3);
  endfunction

  function automatic logic [DLY_W-1:0] dec_tras(input logic [1:0] code);
    return DLY_W'(8) - DLY_W'(code);
  endfunction

  function automatic logic [IDLE_W:0] dec_idle(input logic [2:0] code);
    logic [IDLE_W:0] r;
    case (code)
      3'b000:  r = {1'b0, IDLE_W'(0)};
      3'b001:  r = {1'b1, IDLE_W'(0)};
      3'b010:  r = {1'b1, IDLE_W'(8)};
      3'b011:  r = {1'b1, IDLE_W'(16)};
      default: r = {1'b1, IDLE_W'(64)};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/timing_cfg.sv
module timing_cfg
  import bank_timing_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] data_i,
  output timing_t     tim_o
);
  logic [2:0] idle_q;
  logic [1:0] tras_q, cl_q, rcd_q, rp_q;
  logic       cfg_unused_w;

  // reserved bits and the max-open select (both codes map to one limit)
  assign cfg_unused_w = ^{data_i[31:18], data_i[14:11], data_i[8:7], data_i[4]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      tras_q <= '0;
      cl_q   <= '0;
      rcd_q  <= '0;
      rp_q   <= '0;
    end else if (wr_i) begin
      idle_q <= data_i[IDLE_LSB +: 3];
      tras_q <= data_i[TRAS_LSB +: 2];
      cl_q   <= data_i[CL_LSB +: 2];
      rcd_q  <= data_i[RCD_LSB +: 2];
      rp_q   <= data_i[RP_LSB +: 2];
    end
  end

  always_comb begin
    tim_o.dly.trcd = dec_two_three(rcd_q);
    tim_o.dly.trp  = dec_two_three(rp_q);
    tim_o.dly.tcl  = dec_two_three(cl_q);
    tim_o.dly.tras = dec_tras(tras_q);
    {tim_o.idle_en, tim_o.idle_lim} = dec_idle(idle_q);
  end
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import bank_timing_pkg::*;
#(
  parameter int MO_LIMIT = 24000,
  localparam int MO_W    = $clog2(MO_LIMIT + 1)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  bank_dly_t dly_i,
  input  logic      act_i,
  input  logic      rw_i,
  input  logic      pre_i,
  output logic      act_ok_o,
  output logic      rw_ok_o,
  output logic      pre_ok_o,
  output logic      force_o,
  output logic      open_o,
  output logic      viol_o
);
  localparam logic [DLY_W-1:0] SAT = '1;

  logic             open_q, viol_q;
  logic [DLY_W-1:0] act_cnt_q, rw_cnt_q, pre_cnt_q;
  logic [MO_W-1:0]  mo_cnt_q;
  logic             bad_cmd;

  assign act_ok_o = !open_q && (pre_cnt_q >= dly_i.trp);
  assign rw_ok_o  = open_q && (act_cnt_q >= dly_i.trcd);
  assign pre_ok_o = !open_q || ((act_cnt_q >= dly_i.tras) && (rw_cnt_q >= dly_i.tcl));
  assign force_o  = open_q && (mo_cnt_q >= MO_W'(MO_LIMIT));
  assign open_o   = open_q;
  assign viol_o   = viol_q;

  assign bad_cmd = (act_i && !act_ok_o) || (rw_i && !rw_ok_o) || (pre_i && !pre_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      viol_q    <= 1'b0;
      act_cnt_q <= '0;
      rw_cnt_q  <= SAT;
      pre_cnt_q <= SAT;
      mo_cnt_q  <= '0;
    end else begin
      if (bad_cmd) viol_q <= 1'b1;
      if (act_cnt_q != SAT) act_cnt_q <= act_cnt_q + 1'b1;
      if (rw_cnt_q  != SAT) rw_cnt_q  <= rw_cnt_q + 1'b1;
      if (pre_cnt_q != SAT) pre_cnt_q <= pre_cnt_q + 1'b1;
      if (open_q && mo_cnt_q < MO_W'(MO_LIMIT)) mo_cnt_q <= mo_cnt_q + 1'b1;
      if (act_i) begin
        open_q    <= 1'b1;
        act_cnt_q <= DLY_W'(1);
        rw_cnt_q  <= SAT;
        mo_cnt_q  <= MO_W'(1);
      end else if (pre_i && open_q) begin
        open_q    <= 1'b0;
        pre_cnt_q <= DLY_W'(1);
      end else if (rw_i) begin
        rw_cnt_q  <= DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer
  import bank_timing_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_any_i,
  input  logic              hold_i,
  input  logic              any_open_i,
  input  logic              en_i,
  input  logic [IDLE_W-1:0] lim_i,
  output logic              req_o
);
  logic [IDLE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (cmd_any_i)               cnt_q <= '0;
    else if (!hold_i && cnt_q != '1)  cnt_q <= cnt_q + 1'b1;
  end

  assign req_o = en_i && any_open_i && (cnt_q >= lim_i);
endmodule

// File: rtl/bank_timing_unit.sv
module bank_timing_unit
  import bank_timing_pkg::*;
#(
  parameter int ROWS          = 4,
  parameter int BANKS_PER_ROW = 4,
  parameter int CLK_MHZ       = 200,
  parameter int MAX_OPEN_US   = 120,
  localparam int NUM_BANKS    = ROWS * BANKS_PER_ROW,
  localparam int BANK_W       = $clog2(NUM_BANKS),
  localparam int MO_LIMIT     = CLK_MHZ * MAX_OPEN_US
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_wr_i,
  input  logic [31:0]          cfg_data_i,
  input  logic                 cmd_act_i,
  input  logic                 cmd_rw_i,
  input  logic                 cmd_pre_i,
  input  logic                 cmd_prea_i,
  input  logic [BANK_W-1:0]    cmd_bank_i,
  output logic [NUM_BANKS-1:0] act_ok_o,
  output logic [NUM_BANKS-1:0] rw_ok_o,
  output logic [NUM_BANKS-1:0] pre_ok_o,
  output logic [NUM_BANKS-1:0] force_pre_o,
  output logic                 pre_all_req_o,
  output logic [NUM_BANKS-1:0] violation_o
);
  timing_t              tim;
  logic [NUM_BANKS-1:0] open_w;
  logic                 cmd_any;

  timing_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .tim_o  (tim)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank_i == BANK_W'(b));

    bank_tracker #(.MO_LIMIT(MO_LIMIT)) u_trk (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dly_i    (tim.dly),
      .act_i    (cmd_act_i && hit),
      .rw_i     (cmd_rw_i && hit),
      .pre_i    ((cmd_pre_i && hit) || cmd_prea_i),
      .act_ok_o (act_ok_o[b]),
      .rw_ok_o  (rw_ok_o[b]),
      .pre_ok_o (pre_ok_o[b]),
      .force_o  (force_pre_o[b]),
      .open_o   (open_w[b]),
      .viol_o   (violation_o[b])
    );
  end

  assign cmd_any = cmd_act_i | cmd_rw_i | cmd_pre_i | cmd_prea_i;

  idle_timer u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_any_i  (cmd_any),
    .hold_i     (|force_pre_o),
    .any_open_i (|open_w),
    .en_i       (tim.idle_en),
    .lim_i      (tim.idle_lim),
    .req_o      (pre_all_req_o)
  );
endmodule

// File: rtl/bank_timing_unit_chk.sv
module bank_timing_unit_chk #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_W    = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cmd_act_i,
  input logic                 cmd_pre_i,
  input logic [BANK_W-1:0]    cmd_bank_i,
  input logic [NUM_BANKS-1:0] act_ok_o,
  input logic [NUM_BANKS-1:0] rw_ok_o,
  input logic [NUM_BANKS-1:0] pre_ok_o,
  input logic [NUM_BANKS-1:0] force_pre_o,
  input logic                 pre_all_req_o,
  input logic [NUM_BANKS-1:0] violation_o
);
  assert_act_blocks_rw_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_i |=> !rw_ok_o[$past(cmd_bank_i)]);

  assert_ok_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_ok_o & rw_ok_o) == '0);

  assert_act_blocks_pre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_i |=> !pre_ok_o[$past(cmd_bank_i)]);

  assert_pre_blocks_act_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pre_i && rw_ok_o[cmd_bank_i]) |=> !act_ok_o[$past(cmd_bank_i)]);

  assert_req_needs_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_req_o |-> (act_ok_o != '1));

  assert_force_when_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_pre_o & act_ok_o) == '0);

  assert_viol_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(violation_o) & ~violation_o) == '0);
endmodule

bind bank_timing_unit bank_timing_unit_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_act_i     (cmd_act_i),
  .cmd_pre_i     (cmd_pre_i),
  .cmd_bank_i    (cmd_bank_i),
  .act_ok_o      (act_ok_o),
  .rw_ok_o       (rw_ok_o),
  .pre_ok_o      (pre_ok_o),
  .force_pre_o   (force_pre_o),
  .pre_all_req_o (pre_all_req_o),
  .violation_o   (violation_o)
);

// File: tb/bank_timing_unit_bench.sv
`timescale 1ns/1ps
module bank_timing_unit_bench;
  localparam int NB = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_wr_i = 1'b0;
  logic [31:0]   cfg_data_i = '0;
  logic          cmd_act_i = 1'b0, cmd_rw_i = 1'b0, cmd_pre_i = 1'b0, cmd_prea_i = 1'b0;
  logic [3:0]    cmd_bank_i = '0;
  logic [NB-1:0] act_ok_o, rw_ok_o, pre_ok_o, force_pre_o, violation_o;
  logic          pre_all_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bank_timing_unit u_bank_timing_unit (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_data_i(cfg_data_i),
    .cmd_act_i(cmd_act_i), .cmd_rw_i(cmd_rw_i), .cmd_pre_i(cmd_pre_i),
    .cmd_prea_i(cmd_prea_i), .cmd_bank_i(cmd_bank_i), .act_ok_o(act_ok_o),
    .rw_ok_o(rw_ok_o), .pre_ok_o(pre_ok_o), .force_pre_o(force_pre_o),
    .pre_all_req_o(pre_all_req_o), .violation_o(violation_o)
  );

  // timing word / expected {trcd,tras,trp,tcl} nibbles
  localparam logic [31:0] VEC_CFG [5] = '{32'h0000064A, 32'h00000025, 32'hFFFC026F,
                                          32'h00000400, 32'h00000C29};
  localparam logic [15:0] VEC_EXP [5] = '{16'h2522, 16'h3833, 16'h3733, 16'h3633, 16'h2633};

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 act, 1 rw, 2 pre, 3 precharge-all
  task automatic cmd(input int kind, input int bank);
    cmd_bank_i = 4'(bank);
    cmd_act_i  = (kind == 0);
    cmd_rw_i   = (kind == 1);
    cmd_pre_i  = (kind == 2);
    cmd_prea_i = (kind == 3);
    @(negedge clk);
    {cmd_act_i, cmd_rw_i, cmd_pre_i, cmd_prea_i} = '0;
  endtask

  task automatic cfg_write(input logic [31:0] d);
    cfg_data_i = d;
    cfg_wr_i   = 1'b1;
    @(negedge clk);
    cfg_wr_i   = 1'b0;
  endtask

  function automatic bit flag(input int which, input int b);
    case (which)
      0:       return act_ok_o[b];
      1:       return rw_ok_o[b];
      2:       return pre_ok_o[b];
      default: return pre_all_req_o;
    endcase
  endfunction

  // first clock (1 = cycle after the command edge) in which the flag is high
  task automatic first_k(input int which, input int b, output int k);
    k = 1;
    while (!flag(which, b) && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(1);
  endtask

  initial begin : watchdog
    #(5ns * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not complete)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int k, krw, kpre;
    do_reset();

    // R1 reset state
    chk("R1", "act_ok", act_ok_o, 16'hFFFF);
    chk("R1", "rw_ok", rw_ok_o, 0);
    chk("R1", "pre_ok", pre_ok_o, 16'hFFFF);
    chk("R1", "force_pre", force_pre_o, 0);
    chk("R1", "pre_all_req", pre_all_req_o, 0);
    chk("R1", "violation", violation_o, 0);

    // R1 default delays, R11 isolation
    cmd(0, 5);
    chk("R11", "other act_ok", act_ok_o | 16'h0020, 16'hFFFF);
    chk("R11", "other rw_ok", rw_ok_o & ~16'h0020, 0);
    krw = 0; kpre = 0;
    for (int i = 1; i <= 12; i++) begin
      if (krw == 0 && rw_ok_o[5]) krw = i;
      if (kpre == 0 && pre_ok_o[5]) kpre = i;
      step(1);
    end
    chk("R1", "default trcd", krw, 3);
    chk("R1", "default tras", kpre, 8);
    cmd(2, 5);
    first_k(0, 5, k);
    chk("R1", "default trp", k, 3);

    // table: R2 R3 R4 R5 per timing word, one bank each
    for (int v = 0; v < 5; v++) begin
      int b;
      b = 8 + v;
      cfg_write(VEC_CFG[v]);
      cmd(0, b);
      krw = 0; kpre = 0;
      for (int i = 1; i <= 12; i++) begin
        if (krw == 0 && rw_ok_o[b]) krw = i;
        if (kpre == 0 && pre_ok_o[b]) kpre = i;
        step(1);
      end
      chk("R2", $sformatf("trcd vec%0d", v), krw, VEC_EXP[v][15:12]);
      chk("R3", $sformatf("tras vec%0d", v), kpre, VEC_EXP[v][11:8]);
      cmd(1, b);
      first_k(2, b, k);
      chk("R5", $sformatf("rw->pre vec%0d", v), k, VEC_EXP[v][3:0]);
      cmd(2, b);
      first_k(0, b, k);
      chk("R4", $sformatf("trp vec%0d", v), k, VEC_EXP[v][7:4]);
      chk("R9", $sformatf("no false violation vec%0d", v), violation_o, 0);
    end

    // R9 violations
    do_reset();
    cmd(1, 7);
    chk("R9", "rw to closed bank", violation_o, 16'h0080);
    cmd(0, 3);
    cmd(2, 3);
    chk("R9", "early precharge", violation_o, 16'h0088);
    cmd(2, 9);
    chk("R9", "precharge closed bank no violation", violation_o, 16'h0088);
    chk("R9", "precharge closed bank keeps act_ok", act_ok_o[9], 1);
    step(20);
    chk("R9", "sticky", violation_o, 16'h0088);

    // R6 idle encodings
    do_reset();
    begin
      logic [2:0] codes [5] = '{3'b010, 3'b011, 3'b100, 3'b001, 3'b111};
      int         exps  [5] = '{9, 17, 65, 1, 65};
      for (int c = 0; c < 5; c++) begin
        cfg_write(32'(codes[c]) << 15);
        cmd(0, 1);
        first_k(3, 1, k);
        chk("R6", $sformatf("idle code %0d", codes[c]), k, exps[c]);
        step(10);
        cmd(2, 1);
        chk("R6", "no request with all closed", pre_all_req_o, 0);
        step(4);
      end
    end
    cfg_write(32'h0);
    cmd(0, 1);
    step(150);
    chk("R6", "idle code 0 never", pre_all_req_o, 0);
    step(1);
    cmd(2, 1);
    step(4);

    // R7 restart, R10 precharge-all
    cfg_write(32'h0001_0000);
    cmd(0, 1);
    step(5);
    cmd(1, 1);
    first_k(3, 1, k);
    chk("R7", "restart on command", k, 9);
    cmd(0, 6);
    first_k(3, 6, k);
    chk("R10", "request with two open", k, 9);
    cmd(3, 0);
    chk("R10", "banks closed in trp", act_ok_o[1] | act_ok_o[6], 0);
    step(2);
    chk("R10", "all activatable", act_ok_o, 16'hFFFF);
    chk("R10", "request dropped", pre_all_req_o, 0);
    chk("R10", "no violation", violation_o, 0);

    // R8 max open, R7 hold while force pending (bit 11 set)
    do_reset();
    cfg_write(32'h0002_0800);
    cmd(0, 0);
    begin
      int early_req;
      early_req = 0;
      for (int i = 1; i <= 24000; i++) begin
        if (pre_all_req_o) early_req++;
        if (i == 23999) chk("R8", "force before limit", force_pre_o, 0);
        if (i == 24000) chk("R8", "force at limit", force_pre_o, 16'h0001);
        cmd_bank_i = 4'd0;
        cmd_rw_i   = (i % 32 == 0);
        @(negedge clk);
      end
      cmd_rw_i = 1'b0;
      chk("R7", "no idle request under reads", early_req, 0);
    end
    step(100);
    chk("R7", "idle count held while force pending", pre_all_req_o, 0);
    chk("R8", "force sticky until precharge", force_pre_o, 16'h0001);
    cmd(2, 0);
    chk("R8", "force cleared by precharge", force_pre_o, 0);
    chk("R8", "no violation", violation_o, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule